// File: doc/BRIEF.md
# Shared Serial Line Access Arbiter

This block gives one station fair, collision-safe access to a serial transmit line that several stations share. Every station drives the line through an open-drain output, so the line carries the wired AND of all drivers and a driven zero always wins. The arbiter sits between a local framer and that line. It passes NRZ bits from the framer onto the line output, and it watches the real line level on a separate feedback input. It uses that feedback for carrier sense and for bit-level collision detection.

The bus counts as free once enough consecutive ones have been seen on the feedback input. A pending frame waits until then. While the station sends, the arbiter compares each bit it drove with the level it reads back. If it drove a one but reads a zero, another station has taken the line. The arbiter then stops driving zeros at once, tells the framer with a one-cycle loss pulse, and waits to retry.

Fairness comes from a rotating-priority rule. A station that has just finished a frame must see ten idle ones before its next attempt. The others need only eight. The station drops back to eight as soon as some other station has used the line.

States: `ST_IDLE` (no request, line high), `ST_DEFER` (request pending, waiting for an idle bus), `ST_SEND` (driving framer bits) and `ST_TAIL` (the last bit is on the line and its period is being checked). Transitions:
- IDLE→DEFER when a request appears.
- DEFER→IDLE when the request is withdrawn.
- DEFER→SEND, or DEFER→TAIL for a one-bit frame, at a bit boundary on an idle bus.
- SEND→TAIL when the last bit is accepted.
- SEND→DEFER on a collision while the request is held, or SEND→IDLE on a collision without one.
- SEND→IDLE when the request is dropped at a boundary.
- TAIL→IDLE at the next boundary, with success or loss.
- Every state goes to IDLE on reset.

Top module: `bus_access_arbiter`

## Requirements
- R1: A pending frame starts (tx_ack high in a bit_en cycle) only at the boundary where the eighth consecutive one is sampled on line_cxd. It never starts earlier.
- R2: A zero sampled on line_cxd at any boundary clears the count of ones, so a fresh run of eight ones is needed.
- R3: line_txd is 1 whenever no frame is being sent, including while a request waits for a busy bus. tx_ack is never high without tx_req.
- R4: A bit accepted with tx_ack (only in a bit_en cycle) appears on line_txd from the next clock and is held for the whole bit period. The first bit of a frame is accepted at the start boundary.
- R5: If line_txd is 1 and line_cxd reads 0 at a boundary while sending, the current bit is not accepted. tx_lost pulses for exactly one clock, line_txd returns to 1 from the next clock, and after a new idle period the frame restarts from its first bit.
- R6: Right after a successful frame, the next attempt of the same station needs ten consecutive ones.
- R7: Once a zero from another station is seen while this station is not sending, the threshold returns to eight.
- R8: The count of ones saturates, so after a long idle run a new request starts at the first boundary.
- R9: A synchronous active-high reset sets line_txd to 1, clears tx_lost, drops any frame in progress and clears the count of ones.
- R10: After the last bit is accepted, it stays on the line for one bit period. Then line_txd returns to 1 at the next boundary without a loss pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-clock strobe marking each bit boundary |
| tx_req | input | 1 | Framer holds a frame ready to send |
| tx_data | input | 1 | Current frame bit offered by the framer |
| tx_last | input | 1 | Offered bit is the last of the frame |
| tx_ack | output | 1 | Offered bit is accepted this cycle; the framer advances |
| tx_lost | output | 1 | One-clock pulse: arbitration lost, restart the frame |
| line_txd | output | 1 | Open-drain line drive level (1 = released) |
| line_cxd | input | 1 | Sampled level of the shared line |

## Verification
A corrupt count of ones shows up as a start that comes one or more bit periods too early or too late, and it is visible at the first tx_ack after the bus goes quiet. A stale priority flag moves that start by exactly two bit periods, so the bench counts boundaries up to the start rather than just waiting for it. A wrong state shows within one bit period. The line either holds a zero it should have released after a loss, or fails to show the accepted bit on the clock after tx_ack.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DEFER = 2'd1,
        ST_SEND  = 2'd2,
        ST_TAIL  = 2'd3
    } arb_state_t;

endpackage

// File: rtl/bsa_carrier_sense.sv
module bsa_carrier_sense #(
    parameter int IDLE_ONES    = 8,
    parameter int BACKOFF_ONES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic line_cxd,
    input  logic backoff,
    output logic bus_idle
);
    localparam int MAX_ONES = (BACKOFF_ONES > IDLE_ONES) ? BACKOFF_ONES : IDLE_ONES;
    localparam int CNT_W    = $clog2(MAX_ONES + 1);

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_d;
    logic [CNT_W-1:0] limit;

    // Count of consecutive ones including the sample taken at this boundary
    always_comb begin
        if (!line_cxd) begin
            run_d = '0;
        end else if (run_q == CNT_W'(MAX_ONES)) begin
            run_d = run_q;
        end else begin
            run_d = run_q + 1'b1;
        end
        limit    = backoff ? CNT_W'(BACKOFF_ONES) : CNT_W'(IDLE_ONES);
        bus_idle = (run_d >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (bit_en) begin
            run_q <= run_d;
        end
    end

endmodule

// File: rtl/bsa_priority_rotor.sv
module bsa_priority_rotor (
    input  logic clk,
    input  logic rst,
    input  logic won,
    input  logic other_seen,
    output logic backoff
);
    // Set after a successful frame; cleared once another station is seen
    always_ff @(posedge clk) begin
        if (rst) begin
            backoff <= 1'b0;
        end else if (won) begin
            backoff <= 1'b1;
        end else if (other_seen) begin
            backoff <= 1'b0;
        end
    end

endmodule

// File: rtl/bsa_collision_detect.sv
module bsa_collision_detect (
    input  logic bit_en,
    input  logic sending,
    input  logic line_txd,
    input  logic line_cxd,
    output logic collide
);
    // Released (1) locally but pulled low by someone else during the period
    assign collide = bit_en && sending && line_txd && !line_cxd;

endmodule

// File: rtl/bus_access_arbiter.sv
module bus_access_arbiter
    import bsa_pkg::*;
#(
    parameter int IDLE_ONES    = 8,
    parameter int BACKOFF_ONES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic tx_req,
    input  logic tx_data,
    input  logic tx_last,
    output logic tx_ack,
    output logic tx_lost,
    output logic line_txd,
    input  logic line_cxd
);
    arb_state_t state;
    arb_state_t state_nxt;

    logic bus_idle;
    logic backoff;
    logic collide;
    logic sending;
    logic quiet;
    logic take_bit;
    logic release_line;
    logic lose;
    logic win;
    logic other_seen;

    assign sending    = (state == ST_SEND) || (state == ST_TAIL);
    assign quiet      = (state == ST_IDLE) || (state == ST_DEFER);
    assign other_seen = (bit_en && quiet && !line_cxd) || lose;

    bsa_carrier_sense #(
        .IDLE_ONES    (IDLE_ONES),
        .BACKOFF_ONES (BACKOFF_ONES)
    ) u_sense (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .line_cxd (line_cxd),
        .backoff  (backoff),
        .bus_idle (bus_idle)
    );

    bsa_priority_rotor u_rotor (
        .clk        (clk),
        .rst        (rst),
        .won        (win),
        .other_seen (other_seen),
        .backoff    (backoff)
    );

    bsa_collision_detect u_coll (
        .bit_en   (bit_en),
        .sending  (sending),
        .line_txd (line_txd),
        .line_cxd (line_cxd),
        .collide  (collide)
    );

    // Next state and per-cycle decisions
    always_comb begin
        state_nxt    = state;
        take_bit     = 1'b0;
        release_line = 1'b0;
        lose         = 1'b0;
        win          = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (tx_req) begin
                    state_nxt = ST_DEFER;
                end
            end
            ST_DEFER: begin
                if (!tx_req) begin
                    state_nxt = ST_IDLE;
                end else if (bit_en && bus_idle) begin
                    take_bit  = 1'b1;
                    state_nxt = tx_last ? ST_TAIL : ST_SEND;
                end
            end
            ST_SEND: begin
                if (bit_en) begin
                    if (collide) begin
                        lose         = 1'b1;
                        release_line = 1'b1;
                        state_nxt    = tx_req ? ST_DEFER : ST_IDLE;
                    end else if (!tx_req) begin
                        release_line = 1'b1;
                        state_nxt    = ST_IDLE;
                    end else begin
                        take_bit  = 1'b1;
                        state_nxt = tx_last ? ST_TAIL : ST_SEND;
                    end
                end
            end
            ST_TAIL: begin
                if (bit_en) begin
                    release_line = 1'b1;
                    lose         = collide;
                    win          = !collide;
                    state_nxt    = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    assign tx_ack = take_bit;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            line_txd <= 1'b1;
            tx_lost  <= 1'b0;
        end else begin
            tx_lost <= lose;
            if (take_bit) begin
                line_txd <= tx_data;
            end else if (release_line) begin
                line_txd <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bsa_checker.sv
module bsa_checker
    import bsa_pkg::*;
#(
    parameter int IDLE_ONES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic       tx_req,
    input logic       tx_data,
    input logic       tx_ack,
    input logic       tx_lost,
    input logic       line_txd,
    input logic       line_cxd,
    input arb_state_t state
);
    localparam int OW = $clog2(IDLE_ONES + 1);

    logic [OW-1:0] ones_q;
    logic [OW-1:0] ones_d;

    always_comb begin
        if (!line_cxd) begin
            ones_d = '0;
        end else if (ones_q == OW'(IDLE_ONES)) begin
            ones_d = ones_q;
        end else begin
            ones_d = ones_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q <= '0;
        end else if (bit_en) begin
            ones_q <= ones_d;
        end
    end

    AST_START_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEFER && tx_ack) |-> (ones_d == OW'(IDLE_ONES))); // R1

    AST_QUIET_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_DEFER) |-> line_txd); // R3

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        tx_ack |-> tx_req); // R3

    AST_ACK_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        tx_ack |-> bit_en); // R4

    AST_BIT_ON_LINE: assert property (@(posedge clk) disable iff (rst)
        tx_ack |=> (line_txd == $past(tx_data))); // R4

    AST_LINE_STEADY: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(line_txd)); // R4

    AST_LOST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tx_lost |=> !tx_lost); // R5

    AST_LOST_RELEASED: assert property (@(posedge clk) disable iff (rst)
        tx_lost |-> line_txd); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (line_txd && !tx_lost)); // R9

endmodule

bind bus_access_arbiter bsa_checker #(
    .IDLE_ONES (IDLE_ONES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .tx_req   (tx_req),
    .tx_data  (tx_data),
    .tx_ack   (tx_ack),
    .tx_lost  (tx_lost),
    .line_txd (line_txd),
    .line_cxd (line_cxd),
    .state    (state)
);

// File: tb/sim_bus_access_arbiter.sv
module sim_bus_access_arbiter;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic tx_req = 1'b0;
    logic tx_data = 1'b1;
    logic tx_last = 1'b0;
    logic other = 1'b1;
    logic tx_ack;
    logic tx_lost;
    logic line_txd;
    logic line_cxd;

    int total = 0;
    int bad = 0;

    logic [15:0] fr_bits = 16'h0000;
    int fr_len = 0;
    int fr_idx = 0;

    logic s_ack, s_lost, s_txd;

    always #2 clk = ~clk;

    // Wired AND of this station and one other station
    assign line_cxd = line_txd & other;

    bus_access_arbiter u0 (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .tx_req   (tx_req),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .tx_ack   (tx_ack),
        .tx_lost  (tx_lost),
        .line_txd (line_txd),
        .line_cxd (line_cxd)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One bit period: three plain clocks, then the boundary clock
    task automatic step(input logic oth);
        other  = oth;
        bit_en = 1'b0;
        repeat (3) begin
            @(posedge clk);
            #1;
        end
        bit_en = 1'b1;
        if (fr_idx < fr_len) begin
            tx_data = fr_bits[fr_idx];
            tx_last = (fr_idx == fr_len - 1);
        end else begin
            tx_data = 1'b1;
            tx_last = 1'b0;
        end
        #0.5;
        s_ack = tx_ack;
        @(posedge clk);
        #1;
        bit_en = 1'b0;
        s_lost = tx_lost;
        s_txd  = line_txd;
        if (s_ack) begin
            fr_idx++;
            if (fr_idx == fr_len) tx_req = 1'b0;
        end
        if (s_lost) fr_idx = 0;
    endtask

    task automatic do_reset();
        rst    = 1'b1;
        bit_en = 1'b0;
        tx_req = 1'b0;
        other  = 1'b1;
        fr_idx = 0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic load_frame();
        fr_bits = 16'h037E;
        fr_len  = 12;
        fr_idx  = 0;
        tx_req  = 1'b1;
    endtask

    task automatic wait_start(input int exp, input string tag);
        int n = 0;
        bit high = 1'b1;
        for (int k = 0; k < exp + 3; k++) begin
            step(1'b1);
            n++;
            if (s_ack) break;
            if (!s_txd) high = 1'b0;
        end
        chk(s_ack && n == exp, tag, "boundaries until start", n, exp);
        chk(high, "R3", "line high while deferring", int'(high), 1);
        chk(s_txd == fr_bits[0], "R4", "first bit on line", int'(s_txd), int'(fr_bits[0]));
    endtask

    task automatic finish_frame();
        int guard = 0;
        while (fr_idx < fr_len && guard < 40) begin
            step(1'b1);
            guard++;
            chk(s_ack, "R4", "bit accepted each boundary", int'(s_ack), 1);
            if (s_ack) chk(s_txd == fr_bits[fr_idx-1], "R4", "accepted bit driven",
                           int'(s_txd), int'(fr_bits[fr_idx-1]));
        end
        chk(s_txd == 1'b0, "R10", "last bit held on line", int'(s_txd), 0);
        step(1'b1);
        chk(s_txd == 1'b1 && !s_lost, "R10", "line released after tail", int'(s_txd), 1);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(line_txd == 1'b1, "R9", "line after reset", int'(line_txd), 1);
        chk(tx_lost == 1'b0, "R9", "lost after reset", int'(tx_lost), 0);
        chk(tx_ack == 1'b0, "R9", "ack after reset", int'(tx_ack), 0);
    endtask

    task automatic t_first_access();
        do_reset();
        load_frame();
        wait_start(8, "R1");
        finish_frame();
    endtask

    task automatic t_busy_clears();
        bit high = 1'b1;
        do_reset();
        load_frame();
        for (int k = 0; k < 5; k++) begin
            step(1'b1);
            if (s_ack || !s_txd) high = 1'b0;
        end
        step(1'b0);
        if (s_ack || !s_txd) high = 1'b0;
        chk(high, "R3", "no drive while bus busy", int'(high), 1);
        wait_start(8, "R2");
    endtask

    task automatic t_backoff();
        do_reset();
        load_frame();
        wait_start(8, "R1");
        finish_frame();
        load_frame();
        wait_start(10, "R6");
    endtask

    task automatic t_restore();
        do_reset();
        load_frame();
        wait_start(8, "R1");
        finish_frame();
        step(1'b0);
        step(1'b0);
        chk(s_txd == 1'b1, "R3", "line high with no request", int'(s_txd), 1);
        load_frame();
        wait_start(8, "R7");
    endtask

    task automatic t_collision();
        do_reset();
        load_frame();
        wait_start(8, "R1");
        step(1'b1);
        chk(s_ack && s_txd == 1'b1, "R4", "second bit driven high", int'(s_txd), 1);
        step(1'b0);
        chk(!s_ack, "R5", "no accept on collision", int'(s_ack), 0);
        chk(s_lost, "R5", "loss pulse", int'(s_lost), 1);
        chk(s_txd == 1'b1, "R5", "line released on loss", int'(s_txd), 1);
        step(1'b0);
        chk(!s_lost && s_txd == 1'b1, "R5", "pulse ends and line stays high",
            int'(s_lost), 0);
        wait_start(8, "R5");
    endtask

    task automatic t_saturate();
        bit high = 1'b1;
        do_reset();
        fr_len = 0;
        fr_idx = 0;
        for (int k = 0; k < 20; k++) begin
            step(1'b1);
            if (!s_txd || s_ack) high = 1'b0;
        end
        chk(high, "R3", "idle line without request", int'(high), 1);
        load_frame();
        wait_start(1, "R8");
    endtask

    task automatic t_reset_midframe();
        do_reset();
        load_frame();
        wait_start(8, "R1");
        step(1'b1);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk(line_txd == 1'b1, "R9", "line after mid-frame reset", int'(line_txd), 1);
        chk(tx_ack == 1'b0, "R9", "no accept in reset", int'(tx_ack), 0);
        rst    = 1'b0;
        fr_idx = 0;
        wait_start(8, "R9");
    endtask

    initial begin
        t_reset_state();
        t_first_access();
        t_busy_clears();
        t_backoff();
        t_restore();
        t_collision();
        t_saturate();
        t_reset_midframe();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule